// File: doc/BRIEF.md
# Serial Bus Channel Command Sequencer

This block turns one client request into the register accesses that a serial-bus channel needs. It handles three request kinds: read, write, and control. Each request carries an 8-bit client opcode, a 4-bit slave ID, a 16-bit register address, a byte count given as count minus one, and up to eight bytes of write data. The block first checks the request and maps the client opcode onto a 5-bit channel opcode. It then builds a packed 32-bit command word and steps through the channel register port. For a write it loads the data words and then the command. For a read it issues the command and collects the data once the channel reports completion.

After the command word, the block polls the channel status register at a fixed spacing. A prescaler that counts clock cycles sets this spacing to one microsecond. The block stops polling when the done flag appears or when the poll budget runs out. The client receives exactly one response pulse for each accepted request. The response carries a 3-bit result code and, for a successful read, the assembled read bytes.

Control requests carry only an opcode and a slave ID. They issue the reset, sleep, shutdown and wakeup commands.

Top module: `chan_cmd_seq`

## Requirements
- R1: The command word holds the channel opcode in bits [31:27] and the slave ID in [23:20]. For read and write requests the address sits in [19:4] and the count-minus-one in [2:0]. All other bits are zero.
- R2: A read or write request whose count-minus-one field (4 bits) is 8 or more gets result code 1 (invalid). No channel access takes place.
- R3: Write byte k (bits 8k+7:8k of the request data) goes into byte k mod 4 of data word 0 (select 2) for k below 4, and of data word 1 (select 3) otherwise. Bytes beyond the count are sent as zero. Data word 1 is written only when the count-minus-one exceeds 3.
- R4: Read requests (kind 0) map client opcodes 0x60–0x7F to 15, 0x20–0x2F to 13, and 0x38–0x3F to 1. Any other read opcode gives result code 1 with no channel access.
- R5: Write requests (kind 1) map 0x40–0x5F to 14, 0x00–0x0F to 2, 0x30–0x37 to 0, and 0x80–0xFF to 16. Any other write opcode gives result code 1. Request kind 3 is also invalid.
- R6: A write loads its data words before the command word (select 0). A read writes only the command word, and it reads data words 0 and 1 (selects 4 and 5) only after a status read (select 1) that shows done. The channel never sees a read and a write in the same cycle.
- R7: Status bit 0 is done, bit 1 failure, bit 2 denied, bit 3 dropped. Error bits are ignored until done is set. With done set, the block returns denied (code 2) ahead of failure (code 3), failure ahead of dropped (code 4), and reports success (code 0) otherwise.
- R8: Consecutive status reads are exactly CYCLES_PER_US clock cycles apart. After MAX_POLLS status reads (default 100) without done, the result is timeout (code 5).
- R9: A control request (kind 2) with code 0–3 (reset, sleep, shutdown, wakeup) issues channel opcode 3–6 with only the opcode and slave ID set. Codes above 3 are invalid.
- R10: rsp_valid is a one-cycle pulse, and busy falls in the next cycle. A request presented while busy is high is ignored.
- R11: On a successful read, response byte k comes from byte k mod 4 of read word k/4. Bytes beyond the count, and all bytes of a failed request, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_kind | input | 2 | 0 read, 1 write, 2 control |
| req_opc | input | 8 | Client opcode, or control code 0–3 |
| req_sid | input | 4 | Slave ID |
| req_addr | input | 16 | Register address |
| req_bcm1 | input | 4 | Byte count minus one |
| req_wdata | input | 64 | Write bytes, byte 0 in bits 7:0 |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 3 | 0 ok, 1 invalid, 2 denied, 3 failure, 4 dropped, 5 timeout |
| rsp_rdata | output | 64 | Read bytes, byte 0 in bits 7:0 |
| ch_wr_en | output | 1 | Channel register write strobe |
| ch_rd_en | output | 1 | Channel register read strobe |
| ch_sel | output | 3 | 0 command, 1 status, 2/3 write words, 4/5 read words |
| ch_wdata | output | 32 | Channel write value |
| ch_rdata | input | 32 | Channel read value, same cycle as ch_rd_en |

## Verification
A wrong internal state shows up at the channel port, usually within one access. Possible symptoms are:
- a misrouted opcode range, which puts a wrong opcode field into the very next command write;
- a count compare that is off by one, which adds or drops a write to data word 1 before the command;
- an inverted status priority, which returns a different result code in the pulse after the done poll.

Faults in the poll counter or prescaler take longer to appear. They change the spacing between status reads by the second poll, or the total number of polls before timeout, which is seen MAX_POLLS intervals after the command.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
   localparam int SID_W   = 4;
   localparam int ADDR_W  = 16;
   localparam int WORD_W  = 32;
   localparam int NBYTES  = 8;
   localparam int DATA_W  = 8 * NBYTES;
   localparam int OP_W    = 5;

   localparam int STAT_DONE = 0;
   localparam int STAT_FAIL = 1;
   localparam int STAT_DENY = 2;
   localparam int STAT_DROP = 3;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_CTRL  = 2'd2
   } req_kind_e;

   typedef enum logic [2:0] {
      RES_OK      = 3'd0,
      RES_BADREQ  = 3'd1,
      RES_DENIED  = 3'd2,
      RES_FAILED  = 3'd3,
      RES_DROPPED = 3'd4,
      RES_TIMEOUT = 3'd5
   } result_e;

   typedef enum logic [2:0] {
      SEL_CMD  = 3'd0,
      SEL_STAT = 3'd1,
      SEL_WD0  = 3'd2,
      SEL_WD1  = 3'd3,
      SEL_RD0  = 3'd4,
      SEL_RD1  = 3'd5
   } chsel_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_WD0, ST_WD1, ST_CMD, ST_POLL,
      ST_WAIT, ST_RD0, ST_RD1, ST_RESP
   } state_e;
endpackage

// File: rtl/chseq_opc_xlate.sv
module chseq_opc_xlate
   import chseq_pkg::*;
(
   input  logic [1:0]      kind,
   input  logic [7:0]      opc,
   output logic [OP_W-1:0] ch_op,
   output logic            legal
);
   always_comb begin
      ch_op = '0;
      legal = 1'b0;
      case (kind)
         KIND_READ: begin
            if (opc[7:5] == 3'b011) begin
               ch_op = 5'd15; legal = 1'b1;
            end else if (opc[7:4] == 4'h2) begin
               ch_op = 5'd13; legal = 1'b1;
            end else if (opc[7:3] == 5'b00111) begin
               ch_op = 5'd1;  legal = 1'b1;
            end
         end
         KIND_WRITE: begin
            if (opc[7:5] == 3'b010) begin
               ch_op = 5'd14; legal = 1'b1;
            end else if (opc[7:4] == 4'h0) begin
               ch_op = 5'd2;  legal = 1'b1;
            end else if (opc[7:3] == 5'b00110) begin
               ch_op = 5'd0;  legal = 1'b1;
            end else if (opc[7]) begin
               ch_op = 5'd16; legal = 1'b1;
            end
         end
         KIND_CTRL: begin
            if (opc[7:2] == 6'd0) begin
               ch_op = 5'd3 + {3'd0, opc[1:0]};
               legal = 1'b1;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/chseq_byte_mask.sv
module chseq_byte_mask #(
   parameter int NB = 8
) (
   input  logic [$clog2(NB)-1:0] last_idx,
   input  logic [8*NB-1:0]       din,
   output logic [8*NB-1:0]       dout
);
   localparam int IW = $clog2(NB);
   for (genvar g = 0; g < NB; g++) begin : g_byte
      assign dout[8*g +: 8] = (IW'(g) <= last_idx) ? din[8*g +: 8] : 8'h00;
   end
endmodule

// File: rtl/chseq_tick_timer.sv
module chseq_tick_timer #(
   parameter int CYCLES_PER_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int TW = (CYCLES_PER_US > 2) ? $clog2(CYCLES_PER_US) : 1;
   localparam logic [TW-1:0] RELOAD = TW'(CYCLES_PER_US - 2);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= RELOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/chan_cmd_seq.sv
module chan_cmd_seq
   import chseq_pkg::*;
#(
   parameter int CYCLES_PER_US = 50,
   parameter int MAX_POLLS     = 100
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [1:0]  req_kind,
   input  logic [7:0]  req_opc,
   input  logic [3:0]  req_sid,
   input  logic [15:0] req_addr,
   input  logic [3:0]  req_bcm1,
   input  logic [63:0] req_wdata,
   output logic        busy,
   output logic        rsp_valid,
   output logic [2:0]  rsp_code,
   output logic [63:0] rsp_rdata,
   output logic        ch_wr_en,
   output logic        ch_rd_en,
   output logic [2:0]  ch_sel,
   output logic [31:0] ch_wdata,
   input  logic [31:0] ch_rdata
);
   localparam int PCNT_W = $clog2(MAX_POLLS + 1);
   localparam logic [PCNT_W-1:0] LAST_POLL = PCNT_W'(MAX_POLLS - 1);

   if (CYCLES_PER_US < 2) begin : g_bad_cycles
      $error("CYCLES_PER_US must be at least 2");
   end
   if (MAX_POLLS < 1) begin : g_bad_polls
      $error("MAX_POLLS must be at least 1");
   end

   state_e              st_q;
   req_kind_e           kind_q;
   logic [2:0]          bc_q;
   logic [WORD_W-1:0]   cmd_q;
   logic [DATA_W-1:0]   wdata_q, rdata_q;
   result_e             res_q;
   logic [PCNT_W-1:0]   pcnt_q;

   logic [OP_W-1:0]     x_op;
   logic                x_legal, req_ok, take;
   logic [DATA_W-1:0]   wmask, rmask;
   logic                tmr_load, tmr_exp;
   logic                st_done, st_deny, st_fail, st_drop;

   chseq_opc_xlate u_xlate (
      .kind (req_kind), .opc (req_opc), .ch_op (x_op), .legal (x_legal)
   );

   chseq_byte_mask #(.NB(NBYTES)) u_wmask (
      .last_idx (req_bcm1[2:0]), .din (req_wdata), .dout (wmask)
   );

   chseq_byte_mask #(.NB(NBYTES)) u_rmask (
      .last_idx (bc_q), .din (rdata_q), .dout (rmask)
   );

   chseq_tick_timer #(.CYCLES_PER_US(CYCLES_PER_US)) u_tmr (
      .clk (clk), .rst_n (rst_n), .load (tmr_load), .expired (tmr_exp)
   );

   assign take    = (st_q == ST_IDLE) && req_valid;
   assign req_ok  = x_legal && ((req_kind == KIND_CTRL) || !req_bcm1[3]);
   assign st_done = ch_rdata[STAT_DONE];
   assign st_deny = ch_rdata[STAT_DENY];
   assign st_fail = ch_rdata[STAT_FAIL];
   assign st_drop = ch_rdata[STAT_DROP];
   assign tmr_load = (st_q == ST_POLL) && !st_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         kind_q  <= KIND_READ;
         bc_q    <= '0;
         cmd_q   <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         res_q   <= RES_OK;
         pcnt_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (take) begin
               kind_q  <= req_kind_e'(req_kind);
               bc_q    <= req_bcm1[2:0];
               wdata_q <= wmask;
               rdata_q <= '0;
               res_q   <= RES_OK;
               if (req_kind == KIND_CTRL)
                  cmd_q <= {x_op, 3'b000, req_sid, 20'd0};
               else
                  cmd_q <= {x_op, 3'b000, req_sid, req_addr, 1'b0, req_bcm1[2:0]};
               if (!req_ok) begin
                  res_q <= RES_BADREQ;
                  st_q  <= ST_RESP;
               end else if (req_kind == KIND_WRITE) begin
                  st_q  <= ST_WD0;
               end else begin
                  st_q  <= ST_CMD;
               end
            end
            ST_WD0: st_q <= (bc_q > 3'd3) ? ST_WD1 : ST_CMD;
            ST_WD1: st_q <= ST_CMD;
            ST_CMD: begin
               pcnt_q <= '0;
               st_q   <= ST_POLL;
            end
            ST_POLL: begin
               if (st_done) begin
                  if (st_deny) begin
                     res_q <= RES_DENIED;  st_q <= ST_RESP;
                  end else if (st_fail) begin
                     res_q <= RES_FAILED;  st_q <= ST_RESP;
                  end else if (st_drop) begin
                     res_q <= RES_DROPPED; st_q <= ST_RESP;
                  end else begin
                     st_q <= (kind_q == KIND_READ) ? ST_RD0 : ST_RESP;
                  end
               end else if (pcnt_q == LAST_POLL) begin
                  res_q <= RES_TIMEOUT;
                  st_q  <= ST_RESP;
               end else begin
                  pcnt_q <= pcnt_q + 1'b1;
                  st_q   <= ST_WAIT;
               end
            end
            ST_WAIT: if (tmr_exp) st_q <= ST_POLL;
            ST_RD0: begin
               rdata_q[WORD_W-1:0] <= ch_rdata;
               st_q <= (bc_q > 3'd3) ? ST_RD1 : ST_RESP;
            end
            ST_RD1: begin
               rdata_q[DATA_W-1:WORD_W] <= ch_rdata;
               st_q <= ST_RESP;
            end
            ST_RESP: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ch_wr_en = 1'b0;
      ch_rd_en = 1'b0;
      ch_sel   = SEL_CMD;
      ch_wdata = '0;
      case (st_q)
         ST_WD0:  begin ch_wr_en = 1'b1; ch_sel = SEL_WD0; ch_wdata = wdata_q[WORD_W-1:0]; end
         ST_WD1:  begin ch_wr_en = 1'b1; ch_sel = SEL_WD1; ch_wdata = wdata_q[DATA_W-1:WORD_W]; end
         ST_CMD:  begin ch_wr_en = 1'b1; ch_sel = SEL_CMD; ch_wdata = cmd_q; end
         ST_POLL: begin ch_rd_en = 1'b1; ch_sel = SEL_STAT; end
         ST_RD0:  begin ch_rd_en = 1'b1; ch_sel = SEL_RD0; end
         ST_RD1:  begin ch_rd_en = 1'b1; ch_sel = SEL_RD1; end
         default: ;
      endcase
   end

   assign busy      = (st_q != ST_IDLE);
   assign rsp_valid = (st_q == ST_RESP);
   assign rsp_code  = res_q;
   assign rsp_rdata = (res_q == RES_OK) ? rmask : '0;
endmodule

// File: rtl/chseq_checker.sv
module chseq_checker #(
   parameter int MAX_POLLS = 100
) (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        rsp_valid,
   input logic [2:0]  rsp_code,
   input logic        ch_wr_en,
   input logic        ch_rd_en,
   input logic [2:0]  ch_sel,
   input logic [31:0] ch_wdata,
   input logic [31:0] ch_rdata
);
   logic        cmd_sent_q, done_seen_q;
   logic [3:0]  stat_q;
   int unsigned polls_q;
   logic        cmd_wr, stat_rd, data_rd, wd_wr;
   logic [4:0]  cmd_op;

   assign cmd_wr  = ch_wr_en && (ch_sel == 3'd0);
   assign wd_wr   = ch_wr_en && ((ch_sel == 3'd2) || (ch_sel == 3'd3));
   assign stat_rd = ch_rd_en && (ch_sel == 3'd1);
   assign data_rd = ch_rd_en && ((ch_sel == 3'd4) || (ch_sel == 3'd5));
   assign cmd_op  = ch_wdata[31:27];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_sent_q  <= 1'b0;
         done_seen_q <= 1'b0;
         stat_q      <= '0;
         polls_q     <= 0;
      end else begin
         if (cmd_wr) begin
            cmd_sent_q  <= 1'b1;
            done_seen_q <= 1'b0;
            stat_q      <= '0;
            polls_q     <= 0;
         end else if (rsp_valid) begin
            cmd_sent_q  <= 1'b0;
            done_seen_q <= 1'b0;
            stat_q      <= '0;
         end
         if (stat_rd) begin
            stat_q  <= ch_rdata[3:0];
            polls_q <= polls_q + 1;
            if (ch_rdata[0]) done_seen_q <= 1'b1;
         end
      end
   end

   a_r6_single_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(ch_wr_en && ch_rd_en));
   a_r6_data_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd |-> done_seen_q);
   a_r6_wdata_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      wd_wr |-> !cmd_sent_q);
   a_r8_poll_budget: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |-> (polls_q < MAX_POLLS));
   a_r7_denied_first: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && stat_q[0] && stat_q[2]) |-> (rsp_code == 3'd2));
   a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   a_r10_idle_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !busy);
   a_r1_cmd_opcode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> (cmd_op inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6,
                                 5'd13, 5'd14, 5'd15, 5'd16}));
endmodule

bind chan_cmd_seq chseq_checker #(.MAX_POLLS(MAX_POLLS)) u_chseq_chk (
   .clk (clk), .rst_n (rst_n), .busy (busy), .rsp_valid (rsp_valid),
   .rsp_code (rsp_code), .ch_wr_en (ch_wr_en), .ch_rd_en (ch_rd_en),
   .ch_sel (ch_sel), .ch_wdata (ch_wdata), .ch_rdata (ch_rdata)
);

// File: tb/tb_chan_cmd_seq.sv
module tb_chan_cmd_seq;
   localparam int CLK_PERIOD = 10;
   localparam int CPU = 4;
   localparam int NPOLL = 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [7:0]  req_opc = '0;
   logic [3:0]  req_sid = '0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_bcm1 = '0;
   logic [63:0] req_wdata = '0;
   logic        busy, rsp_valid, ch_wr_en, ch_rd_en;
   logic [2:0]  rsp_code, ch_sel;
   logic [63:0] rsp_rdata;
   logic [31:0] ch_wdata, ch_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   chan_cmd_seq #(.CYCLES_PER_US(CPU), .MAX_POLLS(NPOLL)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_opc(req_opc), .req_sid(req_sid), .req_addr(req_addr),
      .req_bcm1(req_bcm1), .req_wdata(req_wdata), .busy(busy),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
      .ch_wr_en(ch_wr_en), .ch_rd_en(ch_rd_en), .ch_sel(ch_sel),
      .ch_wdata(ch_wdata), .ch_rdata(ch_rdata)
   );

   // channel model
   logic [31:0] stat_v = 32'h1, stat_pre = 32'h0, rd0_v = 32'h0, rd1_v = 32'h0;
   int done_after = 0;
   int poll_n = 0, data_reads = 0, cyc = 0, last_poll = 0;
   logic gap_bad = 1'b0;

   assign ch_rdata = (ch_sel == 3'd1) ? ((poll_n >= done_after) ? stat_v : stat_pre) :
                     (ch_sel == 3'd4) ? rd0_v : (ch_sel == 3'd5) ? rd1_v : 32'h0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (ch_wr_en && ch_sel == 3'd0) begin
         poll_n <= 0; gap_bad <= 1'b0; data_reads <= 0;
      end
      if (ch_rd_en && ch_sel == 3'd1) begin
         poll_n <= poll_n + 1;
         if (poll_n != 0 && (cyc - last_poll) != CPU) gap_bad <= 1'b1;
         last_poll <= cyc;
      end
      if (ch_rd_en && (ch_sel == 3'd4 || ch_sel == 3'd5)) data_reads <= data_reads + 1;
   end

   // scoreboard
   int n_cmp = 0, n_bad = 0;
   logic [34:0] exp_wr[$];
   string       exp_wr_tag[$];
   logic [66:0] exp_rsp[$];
   string       exp_rsp_tag[$];

   task automatic chk(string tag, logic [66:0] act, logic [66:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && ch_wr_en) begin
         if (exp_wr.size() == 0) chk("R6 unexpected channel write", {32'd0, ch_sel, ch_wdata}, '1);
         else chk(exp_wr_tag.pop_front(), {32'd0, ch_sel, ch_wdata}, {32'd0, exp_wr.pop_front()});
      end
      if (rst_n && rsp_valid) begin
         if (exp_rsp.size() == 0) chk("R10 unexpected response", {rsp_code, rsp_rdata}, '1);
         else chk(exp_rsp_tag.pop_front(), {rsp_code, rsp_rdata}, exp_rsp.pop_front());
      end
   end

   function automatic logic [63:0] keep(input int bc, input logic [63:0] d);
      logic [63:0] r = '0;
      for (int i = 0; i < 8; i++) if (i <= bc) r[8*i +: 8] = d[8*i +: 8];
      return r;
   endfunction

   function automatic logic [31:0] cmdw(input int op, input int sid, input int addr, input int bc);
      return (32'(op) << 27) | (32'(sid) << 20) | (32'(addr) << 4) | 32'(bc & 7);
   endfunction

   task automatic exp_w(input logic [2:0] sel, input logic [31:0] d, input string tag);
      exp_wr.push_back({sel, d}); exp_wr_tag.push_back(tag);
   endtask

   task automatic exp_r(input logic [2:0] code, input logic [63:0] d, input string tag);
      exp_rsp.push_back({code, d}); exp_rsp_tag.push_back(tag);
   endtask

   task automatic send(input int kind, input int opc, input int sid, input int addr,
                       input int bc, input logic [63:0] wd);
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_kind = 2'(kind); req_opc = 8'(opc); req_sid = 4'(sid);
      req_addr = 16'(addr); req_bcm1 = 4'(bc); req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      while (busy) @(negedge clk);
   endtask

   task automatic wr_ok(input int opc, input int op, input int sid, input int addr,
                        input int bc, input logic [63:0] wd, input string tag);
      logic [63:0] m = keep(bc, wd);
      exp_w(3'd2, m[31:0], {tag, " data word 0"});
      if (bc > 3) exp_w(3'd3, m[63:32], {tag, " data word 1"});
      exp_w(3'd0, cmdw(op, sid, addr, bc), {tag, " command"});
      exp_r(3'd0, 64'd0, {tag, " response"});
      send(1, opc, sid, addr, bc, wd);
   endtask

   task automatic rd_ok(input int opc, input int op, input int sid, input int addr,
                        input int bc, input string tag);
      exp_w(3'd0, cmdw(op, sid, addr, bc), {tag, " command"});
      exp_r(3'd0, keep(bc, {rd1_v, rd0_v}), {tag, " R11 read data"});
      send(0, opc, sid, addr, bc, 64'd0);
   endtask

   task automatic finish_run;
      chk("R10 leftover channel writes", 67'(exp_wr.size()), 67'd0);
      chk("R10 leftover responses", 67'(exp_rsp.size()), 67'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset outputs", {62'd0, busy, rsp_valid, ch_wr_en, ch_rd_en, 1'b0}, 67'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 / R1 / R3 writes
      wr_ok(8'h45, 14, 3, 16'h1234, 1, 64'h8877665544332211, "R5 0x45 R3 two bytes");
      wr_ok(8'h05, 2, 15, 16'hBEEF, 6, 64'h8877665544332211, "R5 0x05 R3 seven bytes");
      wr_ok(8'h33, 0, 1, 16'h00FF, 3, 64'hA1A2A3A4A5A6A7A8, "R5 0x33 R3 four bytes");
      wr_ok(8'h90, 16, 9, 16'hFFFF, 7, 64'h0102030405060708, "R5 0x90 R1 full fields");
      exp_r(3'd1, 64'd0, "R5 write opcode 0x20 invalid");
      send(1, 8'h20, 2, 16'h10, 0, 64'hFF);
      exp_r(3'd1, 64'd0, "R5 kind 3 invalid");
      send(3, 8'h45, 2, 16'h10, 0, 64'hFF);

      // R4 / R11 reads
      rd0_v = 32'hD3C2B1A0; rd1_v = 32'h77665544;
      rd_ok(8'h65, 15, 4, 16'h2040, 5, "R4 0x65");
      rd_ok(8'h25, 13, 5, 16'h0001, 0, "R4 0x25");
      rd_ok(8'h3A, 1, 6, 16'h8000, 2, "R4 0x3A");
      rd_ok(8'h7F, 15, 7, 16'h4321, 7, "R4 0x7F");
      exp_r(3'd1, 64'd0, "R4 read opcode 0x50 invalid");
      send(0, 8'h50, 1, 16'h1, 0, 64'd0);

      // R2 count limit
      exp_r(3'd1, 64'd0, "R2 write count 9 invalid");
      send(1, 8'h45, 1, 16'h1, 8, 64'hFFFF);
      exp_r(3'd1, 64'd0, "R2 read count 16 invalid");
      send(0, 8'h65, 1, 16'h1, 15, 64'd0);

      // R7 priority
      stat_v = 32'hF;
      exp_w(3'd0, cmdw(15, 1, 16'h10, 0), "R7 cmd");
      exp_r(3'd2, 64'd0, "R7 denied over all");
      send(0, 8'h60, 1, 16'h10, 0, 64'd0);
      chk("R6 no data read after error", 67'(data_reads), 67'd0);
      stat_v = 32'hB;
      exp_w(3'd0, cmdw(15, 1, 16'h10, 0), "R7 cmd");
      exp_r(3'd3, 64'd0, "R7 failure over dropped");
      send(0, 8'h60, 1, 16'h10, 0, 64'd0);
      stat_v = 32'h9;
      exp_w(3'd2, 32'h5A, "R7 wd0");
      exp_w(3'd0, cmdw(14, 1, 16'h10, 0), "R7 cmd");
      exp_r(3'd4, 64'd0, "R7 dropped");
      send(1, 8'h40, 1, 16'h10, 0, 64'h5A);

      // R7 error bits before done ignored, R8 spacing
      stat_v = 32'h1; stat_pre = 32'hE; done_after = 3;
      rd_ok(8'h61, 15, 2, 16'h0300, 4, "R7 pre-done bits ignored");
      chk("R8 polls until done", 67'(poll_n), 67'd4);
      chk("R8 poll spacing", 67'(gap_bad), 67'd0);
      chk("R6 both read words fetched", 67'(data_reads), 67'd2);

      // R8 timeout
      done_after = 100000; stat_pre = 32'h0;
      exp_w(3'd0, cmdw(13, 8, 16'h55AA, 1), "R8 cmd");
      exp_r(3'd5, 64'd0, "R8 timeout");
      send(0, 8'h2F, 8, 16'h55AA, 1, 64'd0);
      chk("R8 poll count at timeout", 67'(poll_n), 67'(NPOLL));
      chk("R8 poll spacing at timeout", 67'(gap_bad), 67'd0);
      done_after = 0;

      // R9 control
      exp_w(3'd0, cmdw(5, 11, 0, 0), "R9 shutdown cmd");
      exp_r(3'd0, 64'd0, "R9 shutdown rsp");
      send(2, 2, 11, 16'hFFFF, 7, 64'd0);
      exp_w(3'd0, cmdw(3, 0, 0, 0), "R9 reset cmd");
      exp_r(3'd0, 64'd0, "R9 reset rsp");
      send(2, 0, 0, 16'h1234, 3, 64'd0);
      exp_r(3'd1, 64'd0, "R9 code 5 invalid");
      send(2, 5, 3, 16'h0, 0, 64'd0);

      // R10 request during busy ignored
      done_after = 3;
      exp_w(3'd0, cmdw(15, 3, 16'h0777, 0), "R10 first cmd");
      exp_r(3'd0, keep(0, {rd1_v, rd0_v}), "R10 first rsp");
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd0; req_opc = 8'h60; req_sid = 4'd3;
      req_addr = 16'h0777; req_bcm1 = 4'd0;
      @(negedge clk);
      req_opc = 8'h45; req_kind = 2'd1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R10 busy low after ignored request", {66'd0, busy}, 67'd0);

      finish_run();
   end
endmodule